// File: doc/BRIEF.md
# SD/MMC Card Clock Pacer

This block decides, one base-clock step at a time, whether the card clock of an SD/MMC host toggles, and how fast. An upstream divider supplies `tick`, a one-cycle enable that marks each half period of the card clock at the transfer rate. While the host reports an active command, response or data phase on `busy`, every tick flips the card clock, so one full card clock period spans two ticks.

When `busy` drops, the block keeps toggling for a fixed number of trailing card clock cycles: eight when `tail_long` is set, four when it is clear. After that it follows the idle policy. With `idle_run` clear the clock parks low. With `idle_run` set it keeps running at the full rate or, if `idle_slow` is also set, at one eighth of it. A transfer that starts during the trailing cycles cancels them. The one-eighth prescaler is cleared whenever the bus is not in slow idle, so the first active edge is never delayed.

The output `sck` is a registered level that changes only on a tick. It always completes a high phase before stopping, so it can only park low. The decisions to start and stop are taken while it is low.

Top module: `sdclk_pacer`

## Requirements
- R1: During reset and after reset with `busy`=0 and `idle_run`=0, `sck` is 0 and does not toggle.
- R2: While `busy`=1, `sck` changes value on every clock cycle in which `tick`=1. Starting from a parked-low clock, L active cycles with `tick` held at 1 produce (L+1)/2 rising edges, rounded down.
- R3: With `idle_run`=0, once the trailing cycles are done `sck` stays at 0 until `busy` rises again.
- R4: With `tail_long`=1 and `idle_run`=0, `sck` shows exactly 8 rising edges after `busy` falls, when `tick` is held at 1.
- R5: With `tail_long`=0 and `idle_run`=0, `sck` shows exactly 4 rising edges after `busy` falls.
- R6: With `idle_run`=1 and `idle_slow`=0, `sck` keeps toggling on every tick while idle. This gives 20 rising edges in the 40 cycles after `busy` falls when `tick` is held at 1.
- R7: With `idle_run`=1 and `idle_slow`=1, after the trailing cycles each half period of `sck` lasts 8 ticks. With `tail_long`=0 this gives 6 rising edges in the 40 cycles after `busy` falls.
- R8: `idle_slow` has no effect while `idle_run`=0. The trailing count is unchanged and the clock parks low.
- R9: A rise of `busy` during the trailing cycles cancels them. The next fall of `busy` starts a fresh trailing count.
- R10: `sck` holds its value in every cycle in which `tick`=0.
- R11: When `busy` is 1, `tick` is 1 and `sck` is 0, `sck` is 1 in the next cycle, even if the clock was idling at the slow rate before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Half-period step enable from the divider |
| busy | input | 1 | Command, response or data phase active |
| idle_run | input | 1 | Keep the card clock running while idle |
| idle_slow | input | 1 | Idle clock at one eighth rate (needs `idle_run`) |
| tail_long | input | 1 | 8 trailing cycles after a transfer instead of 4 |
| sck | output | 1 | Card clock level |

## Verification
The assertions check on every cycle that the clock holds between ticks and follows every tick while active. They also check that a parked clock stays low when idle running is off, that the trailing count loads with the selected length when `busy` falls and is cleared while `busy` is high, and that the clock holds across ticks that do not complete a slow-rate step. Only the bench scenarios show the edge counts over a whole transfer end: 4 against 8 trailing cycles, the slow idle rate over a window, the fresh count after a transfer restarted during run-out, and the prompt first edge when a transfer interrupts slow idling.

// File: rtl/sdclk_pacer.sv
module sdclk_pacer #(
  parameter int TAIL_LONG  = 8,
  parameter int TAIL_SHORT = 4,
  parameter int SLOW_DIV   = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic busy,
  input  logic idle_run,
  input  logic idle_slow,
  input  logic tail_long,
  output logic sck
);

  localparam int TW = $clog2(TAIL_LONG + 1);
  localparam int PW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam logic [PW-1:0] PMAX = PW'(SLOW_DIV - 1);

  logic          busy_q;
  logic [TW-1:0] tail;
  logic [PW-1:0] presc;

  wire busy_fall = busy_q & ~busy;
  wire in_tail   = tail != '0;
  wire slow_idle = idle_run & idle_slow & ~busy & ~busy_q & ~in_tail;
  wire run       = busy | busy_q | in_tail | idle_run;
  wire step      = tick & (~slow_idle | (presc == PMAX));
  wire fall_step = step & sck;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= busy;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                 tail <= '0;
    else if (busy)              tail <= '0;
    else if (busy_fall)         tail <= tail_long ? TW'(TAIL_LONG) : TW'(TAIL_SHORT);
    else if (fall_step && in_tail) tail <= tail - 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          presc <= '0;
    else if (!slow_idle) presc <= '0;
    else if (tick)       presc <= (presc == PMAX) ? '0 : presc + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    sck <= 1'b0;
    else if (step) sck <= sck ? 1'b0 : run;

endmodule

// File: rtl/sdclk_pacer_chk.sv
module sdclk_pacer_chk #(
  parameter int TAIL_LONG  = 8,
  parameter int TAIL_SHORT = 4,
  parameter int TW = 4,
  parameter int PW = 3,
  parameter int SLOW_DIV = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          busy,
  input logic          idle_run,
  input logic          idle_slow,
  input logic          tail_long,
  input logic          sck,
  input logic          busy_q,
  input logic [TW-1:0] tail,
  input logic [PW-1:0] presc
);

  assert_hold_no_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(sck));

  assert_active_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy && tick && !sck |=> sck);

  assert_active_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy && tick && sck |=> !sck);

  assert_parked_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !idle_run && !busy && !busy_q && tail == '0 && !sck |=> !sck);

  assert_tail_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |=> tail == ($past(tail_long) ? TW'(TAIL_LONG) : TW'(TAIL_SHORT)));

  assert_cancel_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> tail == '0);

  assert_slow_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    idle_run && idle_slow && !busy && !busy_q && tail == '0 &&
    presc != PW'(SLOW_DIV - 1) |=> $stable(sck));

endmodule

bind sdclk_pacer sdclk_pacer_chk #(
  .TAIL_LONG(TAIL_LONG), .TAIL_SHORT(TAIL_SHORT), .TW(TW), .PW(PW), .SLOW_DIV(SLOW_DIV)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .busy(busy), .idle_run(idle_run),
  .idle_slow(idle_slow), .tail_long(tail_long), .sck(sck),
  .busy_q(busy_q), .tail(tail), .presc(presc)
);

// File: tb/sdclk_pacer_tb.sv
module sdclk_pacer_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 1'b1, busy = 1'b0, idle_run = 1'b0, idle_slow = 1'b0, tail_long = 1'b0;
  logic sck;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sdclk_pacer u_dut (.clk(clk), .rst_n(rst_n), .tick(tick), .busy(busy),
    .idle_run(idle_run), .idle_slow(idle_slow), .tail_long(tail_long), .sck(sck));

  // fields: tail_long[15] idle_run[14] idle_slow[13] busy_len[12:8] expected rises[7:0]
  localparam int NV = 7;
  localparam logic [15:0] VEC [NV] = '{
    {1'b1, 1'b0, 1'b0, 5'd6,  8'd8},
    {1'b0, 1'b0, 1'b0, 5'd7,  8'd4},
    {1'b0, 1'b0, 1'b1, 5'd5,  8'd4},
    {1'b1, 1'b0, 1'b1, 5'd8,  8'd8},
    {1'b0, 1'b1, 1'b0, 5'd6,  8'd20},
    {1'b0, 1'b1, 1'b1, 5'd6,  8'd6},
    {1'b0, 1'b1, 1'b1, 5'd9,  8'd6}
  };

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic count_rises(int n, output int r);
    logic prev;
    r = 0;
    repeat (n) begin
      prev = sck;
      @(negedge clk);
      if (sck && !prev) r++;
    end
  endtask

  task automatic settle();
    int d;
    busy = 1'b0; idle_run = 1'b0; idle_slow = 1'b0; tick = 1'b1;
    count_rises(40, d);
  endtask

  initial begin
    int r;
    string tag;
    repeat (3) @(negedge clk);
    chk("R1 reset level", int'(sck), 0);
    rst_n = 1'b1;
    count_rises(10, r);
    chk("R1 no toggles after reset", r, 0);

    for (int i = 0; i < NV; i++) begin
      tail_long = VEC[i][15]; idle_run = VEC[i][14]; idle_slow = VEC[i][13];
      busy = 1'b1;
      count_rises(int'(VEC[i][12:8]), r);
      chk("R2 active rises", r, (int'(VEC[i][12:8]) + 1) / 2);
      busy = 1'b0;
      count_rises(40, r);
      if (VEC[i][14] && VEC[i][13]) tag = "R7 slow idle rises";
      else if (VEC[i][14])          tag = "R6 running idle rises";
      else if (VEC[i][13])          tag = "R8 slow select ignored";
      else if (VEC[i][15])          tag = "R4 long tail rises";
      else                          tag = "R5 short tail rises";
      chk(tag, r, int'(VEC[i][7:0]));
      if (!VEC[i][14]) begin
        count_rises(10, r);
        chk("R3 parked idle", r, 0);
        chk("R3 parked low", int'(sck), 0);
      end
      settle();
    end

    // R10: ticks withheld while active
    busy = 1'b1;
    count_rises(3, r);
    tick = 1'b0;
    begin
      logic held;
      int changes;
      held = sck; changes = 0;
      repeat (10) begin
        @(negedge clk);
        if (sck != held) changes++;
      end
      chk("R10 hold without tick", changes, 0);
    end
    tick = 1'b1;
    settle();

    // R9: restart during run-out
    tail_long = 1'b1;
    busy = 1'b1; count_rises(6, r);
    busy = 1'b0; count_rises(3, r);
    busy = 1'b1; count_rises(5, r);
    busy = 1'b0; count_rises(40, r);
    chk("R9 fresh tail after restart", r, 8);
    settle();

    // R11: prompt first edge out of slow idle
    idle_run = 1'b1; idle_slow = 1'b1; tail_long = 1'b0;
    count_rises(40, r);
    for (int k = 0; k < 20 && sck; k++) @(negedge clk);
    chk("R11 waited for low phase", int'(sck), 0);
    busy = 1'b1;
    @(negedge clk);
    chk("R11 first active edge", int'(sck), 1);
    busy = 1'b0;
    settle();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule